// File: doc/BRIEF.md
# Write-Safety Fault Monitor

This block supervises the single fault line of a disk-head preamplifier. It tracks the operating mode of the amplifier: sleep, idle, read, write, and a forced bank-write mode used for servo writing. In each mode it folds the relevant analog comparator results, which arrive here as digital flags, into one registered fault output. The meaning of that output depends on the mode. In write mode a fault pulls it high. In read mode a fault pulls it low. In every other mode it sits at a fixed quiet level.

While writing, the monitor checks for an open or grounded write head and for a supply that has dropped out of range. It also watches the write-data line. A counter runs on the system clock and restarts on every level change of write data. When that counter grows past a programmable limit, the data rate is too low and the monitor flags a fault. After each entry into write mode, a blanking window of `BLANK_CYC` cycles suppresses all write faults. In read mode, the head-open and head-short flags are each reported only when their enable bit is set.

Bank-write mode is entered from read mode when the force-select input is held high and the read/write control is then driven low. The mode ends when the read/write control returns high. While bank-write lasts, all detection is off, including the low-supply check. A separate output tells the pad logic when the shared pin may carry the buffered head voltage.

Top module: `wsafe_fault_mon`

## Requirements
- R1: During reset and on the first cycle after it, `fault_o` is 0, `hv_test_o` is 0 and `mode_o` is 0 (sleep).
- R2: `mode_o` is registered one clock after its controls are sampled. The encodings are 0 sleep, 1 idle, 2 read, 3 write, 4 bank-write. `sleep_n` low forces sleep. Otherwise `idle_n` low forces idle. Otherwise `rd_wr_n` high selects read and low selects write.
- R3: When `mode_o` shows sleep, idle or bank-write, `fault_o` is 0 on the next clock, whatever the comparator flags are.
- R4: In write mode, once blanking has ended, any of `cmp_wr_open`, `cmp_wr_short` or `cmp_low_supply` drives `fault_o` to 1 one clock after the flag is sampled. With all write faults clear, `fault_o` is 0.
- R5: After `mode_o` first shows write, no write fault reaches `fault_o` for `BLANK_CYC` cycles. With a flag held from entry, `fault_o` first rises `BLANK_CYC`+1 clocks after `mode_o` becomes 3.
- R6: In write mode, the activity counter restarts on every change of `wdata` level. `fault_o` is raised when the counter exceeds `wd_limit`. Level changes spaced `wd_limit`+1 clocks apart never raise it. After the last change, `fault_o` rises `wd_limit`+2 clocks after that change is sampled. A new change clears the fault two clocks later.
- R7: In read mode, `fault_o` is 0 one clock after (`cmp_rd_open` and `en_rd_open`) or (`cmp_rd_short` and `en_rd_short`) is sampled, and 1 otherwise. A flag whose enable is 0 has no effect.
- R8: Bank-write (`mode_o`=4) is entered when `mode_o` is read, `force_sel` is 1 and `rd_wr_n` is 0. Raising `force_sel` while already in write mode leaves the mode at write.
- R9: Bank-write holds while `rd_wr_n` stays 0, even if `force_sel` drops. It returns to read one clock after `rd_wr_n` is sampled high. All write and low-supply flags are ignored while it lasts.
- R10: `hv_test_o` is 1 one clock after `mode_o` shows read with `en_hv_test` 1 and both `en_rd_open` and `en_rd_short` 0, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sleep_n | input | 1 | 0 puts the amplifier to sleep |
| idle_n | input | 1 | 0 puts the amplifier in idle |
| rd_wr_n | input | 1 | 1 selects read, 0 selects write |
| force_sel | input | 1 | Bank-write force-select flag |
| wdata | input | 1 | Write data, digital level |
| wd_limit | input | CNT_W | Write-data activity limit in clocks |
| cmp_wr_open | input | 1 | Write head open comparator |
| cmp_wr_short | input | 1 | Write head shorted to ground comparator |
| cmp_low_supply | input | 1 | Supply out of tolerance comparator |
| cmp_rd_open | input | 1 | Read head open comparator |
| cmp_rd_short | input | 1 | Read head short comparator |
| en_rd_open | input | 1 | Enable for read head open report |
| en_rd_short | input | 1 | Enable for read head short report |
| en_hv_test | input | 1 | Head-voltage test point enable |
| fault_o | output | 1 | Fault line, level depends on mode |
| hv_test_o | output | 1 | Shared pin carries head voltage |
| mode_o | output | 3 | Current operating mode |

## Verification
`mode_o` follows its controls by one clock. `fault_o` and `hv_test_o` follow `mode_o` by one further clock, so a mode change appears at the fault line two clocks after it is driven. A comparator change inside a steady mode appears one clock later. The write-blanking edge is due `BLANK_CYC`+2 clocks after the read/write control falls. The slow-data fault is due `wd_limit`+2 clocks after the last data change. The bench drives every input on the falling edge and advances by a counted number of rising edges before sampling on the next falling edge. Each check therefore lands on the exact cycle worked out from this register count, and the bench also samples one cycle earlier at the blanking and slow-data boundaries.

// File: rtl/wsafe_pkg.sv
// Shared types for the write-safety fault monitor.
package wsafe_pkg;
    typedef enum logic [2:0] {
        MODE_SLEEP = 3'd0,
        MODE_IDLE  = 3'd1,
        MODE_READ  = 3'd2,
        MODE_WRITE = 3'd3,
        MODE_BANK  = 3'd4
    } wsafe_mode_e;
endpackage

// File: rtl/wsafe_mode_ctl.sv
// Operating-mode register.
// Sleep has priority over idle, and idle over read/write. Bank-write is
// entered only from read when force_sel is high and rd_wr_n goes low.
// Assumes the control inputs are synchronous to clk.
module wsafe_mode_ctl
    import wsafe_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sleep_n,
    input  logic        idle_n,
    input  logic        rd_wr_n,
    input  logic        force_sel,
    output wsafe_mode_e mode_q
);
    wsafe_mode_e mode_d;

    // Next-mode decode from the controls and the current mode.
    always_comb begin
        if (!sleep_n)
            mode_d = MODE_SLEEP;
        else if (!idle_n)
            mode_d = MODE_IDLE;
        else if (mode_q == MODE_BANK)
            mode_d = rd_wr_n ? MODE_READ : MODE_BANK;
        else if (!rd_wr_n)
            mode_d = (mode_q == MODE_READ && force_sel) ? MODE_BANK : MODE_WRITE;
        else
            mode_d = MODE_READ;
    end

    // Mode state register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= MODE_SLEEP;
        else
            mode_q <= mode_d;
    end
endmodule

// File: rtl/wsafe_wd_activity.sv
// Write-data activity checker.
// A counter restarts on each level change of wdata and saturates at its
// maximum. slow_o is set while the count exceeds limit. Outside the
// active window the counter is held at zero and the last level is tracked,
// so entering write mode never sees a false edge.
module wsafe_wd_activity #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             wdata,
    input  logic [CNT_W-1:0] limit,
    output logic             slow_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic             wd_prev;
    logic [CNT_W-1:0] gap_cnt;
    logic             wd_edge;

    // A level change relative to the previous sample.
    assign wd_edge = (wdata != wd_prev);

    // Previous-level tracker.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wd_prev <= 1'b0;
        else
            wd_prev <= wdata;
    end

    // Gap counter: restart on edge, saturate otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !active)
            gap_cnt <= '0;
        else if (wd_edge)
            gap_cnt <= '0;
        else if (gap_cnt != CNT_MAX)
            gap_cnt <= gap_cnt + 1'b1;
    end

    // Slow-data flag.
    assign slow_o = active && (gap_cnt > limit);
endmodule

// File: rtl/wsafe_blank_timer.sv
// Blanking timer after entry into write mode.
// armed_o goes high once BLANK_CYC cycles of continuous activity have
// passed, and drops as soon as active falls. Assumes BLANK_CYC >= 1.
module wsafe_blank_timer #(
    parameter int BLANK_CYC = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    output logic armed_o
);
    localparam int BW = $clog2(BLANK_CYC + 1);
    localparam logic [BW-1:0] LAST = BW'(BLANK_CYC);

    logic [BW-1:0] blank_cnt;

    // Count up to the blanking length while active, clear otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !active)
            blank_cnt <= '0;
        else if (blank_cnt != LAST)
            blank_cnt <= blank_cnt + 1'b1;
    end

    assign armed_o = active && (blank_cnt == LAST);
endmodule

// File: rtl/wsafe_fault_out.sv
// Fault output stage.
// Picks the fault sources for the current mode and applies the
// mode-dependent polarity: write fault = 1, read fault = 0, and quiet
// level 0 in sleep, idle and bank-write. Also decides when the shared
// pin may carry head voltage. Both outputs are registered.
module wsafe_fault_out
    import wsafe_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  wsafe_mode_e mode,
    input  logic        armed,
    input  logic        wr_open,
    input  logic        wr_short,
    input  logic        low_supply,
    input  logic        wd_slow,
    input  logic        rd_open,
    input  logic        rd_short,
    input  logic        en_open,
    input  logic        en_short,
    input  logic        en_hv,
    output logic        fault_o,
    output logic        hv_o
);
    logic wr_hit;
    logic rd_hit;
    logic fault_d;
    logic hv_d;

    // Merge fault sources for each mode.
    always_comb begin
        wr_hit = armed && (wr_open || wr_short || low_supply || wd_slow);
        rd_hit = (rd_open && en_open) || (rd_short && en_short);
        unique case (mode)
            MODE_WRITE: fault_d = wr_hit;
            MODE_READ:  fault_d = !rd_hit;
            default:    fault_d = 1'b0;
        endcase
        hv_d = (mode == MODE_READ) && en_hv && !en_open && !en_short;
    end

    // Output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_o <= 1'b0;
            hv_o    <= 1'b0;
        end else begin
            fault_o <= fault_d;
            hv_o    <= hv_d;
        end
    end
endmodule

// File: rtl/wsafe_fault_mon.sv
// Write-safety fault monitor, top level.
// Chains the mode register, the write-data activity checker, the
// write-entry blanking timer and the output stage. All inputs are
// assumed synchronous to clk. Comparators arrive as digital flags.
module wsafe_fault_mon
    import wsafe_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int BLANK_CYC = 30
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep_n,
    input  logic             idle_n,
    input  logic             rd_wr_n,
    input  logic             force_sel,
    input  logic             wdata,
    input  logic [CNT_W-1:0] wd_limit,
    input  logic             cmp_wr_open,
    input  logic             cmp_wr_short,
    input  logic             cmp_low_supply,
    input  logic             cmp_rd_open,
    input  logic             cmp_rd_short,
    input  logic             en_rd_open,
    input  logic             en_rd_short,
    input  logic             en_hv_test,
    output logic             fault_o,
    output logic             hv_test_o,
    output logic [2:0]       mode_o
);
    wsafe_mode_e mode_q;
    logic        wr_active;
    logic        wd_slow;
    logic        armed;

    assign wr_active = (mode_q == MODE_WRITE);
    assign mode_o    = mode_q;

    wsafe_mode_ctl u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .sleep_n   (sleep_n),
        .idle_n    (idle_n),
        .rd_wr_n   (rd_wr_n),
        .force_sel (force_sel),
        .mode_q    (mode_q)
    );

    wsafe_wd_activity #(.CNT_W(CNT_W)) u_wd (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (wr_active),
        .wdata  (wdata),
        .limit  (wd_limit),
        .slow_o (wd_slow)
    );

    wsafe_blank_timer #(.BLANK_CYC(BLANK_CYC)) u_blank (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (wr_active),
        .armed_o (armed)
    );

    wsafe_fault_out u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode_q),
        .armed      (armed),
        .wr_open    (cmp_wr_open),
        .wr_short   (cmp_wr_short),
        .low_supply (cmp_low_supply),
        .wd_slow    (wd_slow),
        .rd_open    (cmp_rd_open),
        .rd_short   (cmp_rd_short),
        .en_open    (en_rd_open),
        .en_short   (en_rd_short),
        .en_hv      (en_hv_test),
        .fault_o    (fault_o),
        .hv_o       (hv_test_o)
    );
endmodule

// File: rtl/wsafe_fault_mon_chk.sv
// Property checker for wsafe_fault_mon, bound to every instance.
// Watches ports only, plus a write-entry cycle counter of its own.
module wsafe_fault_mon_chk
    import wsafe_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int BLANK_CYC = 30
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sleep_n,
    input logic             idle_n,
    input logic             rd_wr_n,
    input logic             force_sel,
    input logic             cmp_rd_open,
    input logic             cmp_rd_short,
    input logic             en_rd_open,
    input logic             en_rd_short,
    input logic             en_hv_test,
    input logic             fault_o,
    input logic             hv_test_o,
    input logic [2:0]       mode_o
);
    localparam int BW = $clog2(BLANK_CYC + 1);
    logic [BW-1:0] wr_cycles;

    // Cycles spent in write mode since entry, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || mode_o != MODE_WRITE)
            wr_cycles <= '0;
        else if (wr_cycles != BW'(BLANK_CYC))
            wr_cycles <= wr_cycles + 1'b1;
    end

    assert_quiet_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == MODE_SLEEP || mode_o == MODE_IDLE || mode_o == MODE_BANK) |=> !fault_o);

    assert_write_blanked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == MODE_WRITE && wr_cycles != BW'(BLANK_CYC)) |=> !fault_o);

    assert_read_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == MODE_READ && !(cmp_rd_open && en_rd_open) && !(cmp_rd_short && en_rd_short))
        |=> fault_o);

    assert_read_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == MODE_READ && ((cmp_rd_open && en_rd_open) || (cmp_rd_short && en_rd_short)))
        |=> !fault_o);

    assert_bank_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == MODE_READ && sleep_n && idle_n && force_sel && !rd_wr_n)
        |=> mode_o == MODE_BANK);

    assert_bank_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == MODE_BANK && sleep_n && idle_n && rd_wr_n) |=> mode_o == MODE_READ);

    assert_hv_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        hv_test_o |-> $past(mode_o == MODE_READ && en_hv_test && !en_rd_open && !en_rd_short));
endmodule

bind wsafe_fault_mon wsafe_fault_mon_chk #(.CNT_W(CNT_W), .BLANK_CYC(BLANK_CYC)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sleep_n      (sleep_n),
    .idle_n       (idle_n),
    .rd_wr_n      (rd_wr_n),
    .force_sel    (force_sel),
    .cmp_rd_open  (cmp_rd_open),
    .cmp_rd_short (cmp_rd_short),
    .en_rd_open   (en_rd_open),
    .en_rd_short  (en_rd_short),
    .en_hv_test   (en_hv_test),
    .fault_o      (fault_o),
    .hv_test_o    (hv_test_o),
    .mode_o       (mode_o)
);

// File: tb/wsafe_fault_mon_test.sv
// Directed bench: one task per scenario, inputs driven on the falling
// edge, outputs sampled on a falling edge after a counted number of
// rising edges.
module wsafe_fault_mon_test;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 8;
    localparam int BLANK      = 30;

    logic clk = 1'b0;
    logic rst_n, sleep_n, idle_n, rd_wr_n, force_sel, wdata;
    logic [CNT_W-1:0] wd_limit;
    logic c_wo, c_ws, c_lv, c_ro, c_rs, e_ro, e_rs, e_hv;
    logic fault_o, hv_test_o;
    logic [2:0] mode_o;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wsafe_fault_mon #(.CNT_W(CNT_W), .BLANK_CYC(BLANK)) uut (
        .clk(clk), .rst_n(rst_n), .sleep_n(sleep_n), .idle_n(idle_n),
        .rd_wr_n(rd_wr_n), .force_sel(force_sel), .wdata(wdata),
        .wd_limit(wd_limit), .cmp_wr_open(c_wo), .cmp_wr_short(c_ws),
        .cmp_low_supply(c_lv), .cmp_rd_open(c_ro), .cmp_rd_short(c_rs),
        .en_rd_open(e_ro), .en_rd_short(e_rs), .en_hv_test(e_hv),
        .fault_o(fault_o), .hv_test_o(hv_test_o), .mode_o(mode_o)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_fault(input string tag, input bit exp);
        chk(fault_o === exp, tag, int'(fault_o), int'(exp));
    endtask

    task automatic chk_mode(input string tag, input int exp);
        chk(mode_o === 3'(exp), tag, int'(mode_o), exp);
    endtask

    task automatic clear_flags();
        c_wo = 0; c_ws = 0; c_lv = 0; c_ro = 0; c_rs = 0;
    endtask

    task automatic go_read();
        sleep_n = 1; idle_n = 1; rd_wr_n = 1; force_sel = 0;
        tick(2);
    endtask

    // R1: reset state.
    task automatic t_reset();
        rst_n = 0; sleep_n = 1; idle_n = 1; rd_wr_n = 1; force_sel = 0;
        wdata = 0; wd_limit = 8'hFF; clear_flags();
        e_ro = 0; e_rs = 0; e_hv = 1;
        tick(3);
        chk_fault("R1 fault in reset", 0);
        chk(hv_test_o === 0, "R1 hv in reset", int'(hv_test_o), 0);
        chk_mode("R1 mode in reset", 0);
        sleep_n = 0;
        rst_n = 1;
        tick(1);
        chk_mode("R1 mode after reset", 0);
        chk_fault("R1 fault after reset", 0);
        e_hv = 0;
    endtask

    // R2, R3: sleep and idle decode with faults quiet.
    task automatic t_sleep_idle();
        sleep_n = 0; idle_n = 1; rd_wr_n = 0; c_lv = 1; c_wo = 1; c_ro = 1; e_ro = 1;
        tick(1);
        chk_mode("R2 sleep decode", 0);
        tick(1);
        chk_fault("R3 quiet in sleep", 0);
        sleep_n = 1; idle_n = 0;
        tick(1);
        chk_mode("R2 idle decode", 1);
        tick(1);
        chk_fault("R3 quiet in idle", 0);
        clear_flags(); e_ro = 0;
        go_read();
        chk_mode("R2 read decode", 2);
    endtask

    // R7: read faults gated by enables, active-low.
    task automatic t_read();
        go_read();
        chk_fault("R7 read no fault", 1);
        c_ro = 1; e_ro = 0;
        tick(1);
        chk_fault("R7 open ignored when disabled", 1);
        e_ro = 1;
        tick(1);
        chk_fault("R7 open reported", 0);
        c_ro = 0;
        tick(1);
        chk_fault("R7 open cleared", 1);
        c_rs = 1; e_rs = 0;
        tick(1);
        chk_fault("R7 short ignored when disabled", 1);
        e_rs = 1;
        tick(1);
        chk_fault("R7 short reported", 0);
        clear_flags(); e_ro = 0; e_rs = 0;
        tick(1);
    endtask

    // R5, R4: blanking edge and the three write comparators.
    task automatic t_write();
        go_read();
        wd_limit = 8'hFF;
        c_ws = 1; rd_wr_n = 0;
        tick(1);
        chk_mode("R2 write decode", 3);
        tick(BLANK);
        chk_fault("R5 still blanked", 0);
        tick(1);
        chk_fault("R5 fault after blanking", 1);
        c_ws = 0;
        tick(1);
        chk_fault("R4 no write fault", 0);
        c_wo = 1;
        tick(1);
        chk_fault("R4 open head", 1);
        c_wo = 0; c_lv = 1;
        tick(1);
        chk_fault("R4 low supply", 1);
        c_lv = 0;
        tick(1);
        chk_fault("R4 cleared", 0);
    endtask

    // R6: write-data activity window (assumes write mode, armed).
    task automatic t_wd();
        wdata = ~wdata;
        tick(1);
        wd_limit = 8'd4;
        for (int r = 0; r < 4; r++) begin
            wdata = ~wdata;
            for (int c = 0; c < 5; c++) begin
                tick(1);
                chk_fault("R6 steady toggling", 0);
            end
        end
        tick(1);
        chk_fault("R6 one cycle before slow", 0);
        tick(1);
        chk_fault("R6 slow data fault", 1);
        wdata = ~wdata;
        tick(2);
        chk_fault("R6 cleared by edge", 0);
        wd_limit = 8'hFF;
    endtask

    // R8, R9: bank-write entry, suppression, exit, and write-mode force.
    task automatic t_bank();
        go_read();
        force_sel = 1; rd_wr_n = 0; c_lv = 1; c_wo = 1; wd_limit = 8'd2;
        tick(1);
        chk_mode("R8 bank entry", 4);
        force_sel = 0;
        tick(BLANK + 8);
        chk_mode("R9 bank holds", 4);
        chk_fault("R9 detection off in bank", 0);
        rd_wr_n = 1;
        tick(1);
        chk_mode("R9 bank exit", 2);
        clear_flags(); wd_limit = 8'hFF;
        tick(1);
        rd_wr_n = 0;
        tick(1);
        chk_mode("R8 plain write", 3);
        force_sel = 1;
        tick(1);
        chk_mode("R8 force in write ignored", 3);
        force_sel = 0;
    endtask

    // R10: head-voltage pin gating.
    task automatic t_hv();
        go_read();
        e_hv = 1; e_ro = 0; e_rs = 0;
        tick(1);
        chk(hv_test_o === 1, "R10 hv enabled", int'(hv_test_o), 1);
        e_rs = 1;
        tick(1);
        chk(hv_test_o === 0, "R10 hv blocked by enable", int'(hv_test_o), 0);
        e_rs = 0; rd_wr_n = 0;
        tick(2);
        chk(hv_test_o === 0, "R10 hv off in write", int'(hv_test_o), 0);
        e_hv = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_sleep_idle();
        t_read();
        t_write();
        t_wd();
        t_bank();
        t_hv();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule